// File: doc/BRIEF.md
# Staged Memory Access Unit

This block sits between a processor's control unit and its word-addressed memory bus. Every access passes through two internal staging registers: an address holding register and a data holding register. A read places the requested address in the address register, drives it onto the bus with a read strobe, and captures the returned word into the data register. A write loads both registers, then drives them onto the bus with a write strobe. Addresses are 16-bit word addresses; each one selects a full 32-bit word, so there are no byte enables.

The block decodes the latched address into one of three regions: general RAM, the display window at the top of RAM, or the IO space in the upper half of the address range. The display window is flagged on the bus so that a display controller can snoop it. IO addresses never reach RAM. The single live IO address is the terminal data port: a word written there comes out on a character port with a one-cycle valid pulse. Any other IO write is dropped, and any IO read returns zero.

The control unit hands over requests with a valid/ready handshake. Ready is high only while the block is idle. A request that is offered while ready is low is not taken, and its fields must stay stable until it is accepted. Completion is a plain one-cycle done pulse.

Top module: `membus_unit`

## Requirements
- R1: After reset, bus_rd, bus_wr, term_valid and rsp_done are low, req_ready is high, and bus_addr, bus_wdata and rsp_rdata read zero.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low from the edge after acceptance until the done cycle has ended. A request offered while req_ready is low has no effect.
- R3: For a read of a RAM address (bit 15 clear), bus_rd is high for exactly the first cycle after acceptance, with bus_addr equal to the request address. The word on bus_rdata in the following cycle is captured. In the cycle after that, rsp_done is high and rsp_rdata holds the captured word.
- R4: For a write to a RAM address, bus_wr is high for exactly the first cycle after acceptance, with bus_addr and bus_wdata equal to the request address and data. rsp_done is high in the next cycle. bus_rd and bus_wr are never high together.
- R5: During the done cycle, rsp_region reports the region of the address: 0 for general RAM, 1 for the display window 0x7C40..0x7FFF (960 words), and 2 for IO (0x8000..0xFFFF). bus_fbuf is high exactly when a strobe is high for a display-window address.
- R6: A read of any IO address raises no bus_rd and returns rsp_rdata = 0.
- R7: A write to 0xFFF0 raises no bus_wr. Instead, term_valid pulses for the first cycle after acceptance, with term_data equal to the written word.
- R8: A write to any other IO address raises neither bus_wr nor term_valid, and still completes with rsp_done.
- R9: Each accepted request produces exactly one rsp_done pulse, one cycle wide: 3 cycles after acceptance for reads and 2 cycles after for writes.
- R10: bus_addr changes only on an edge that accepts a request, and holds the last address while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Data register contents; read result while rsp_done is high |
| rsp_region | output | 2 | Region code of the latched address |
| bus_addr | output | 16 | Address register driven onto the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 32 | Data register driven onto the bus |
| bus_rdata | input | 32 | RAM read data, valid one cycle after bus_rd |
| bus_fbuf | output | 1 | Strobe targets the display window |
| term_valid | output | 1 | Terminal word valid, one cycle |
| term_data | output | 32 | Terminal word |

## Verification
The assertions assume that RAM answers a read strobe with valid data exactly one cycle later, and that a requester keeps its fields stable while it holds valid with ready low. They also assume that reset is applied before the first request. The bench's RAM model registers its response on the edge that samples bus_rd, and it drives a poison word in every other cycle, so a capture in the wrong cycle is visible. All stimulus changes on the falling edge, and the one deliberate offer made while the block is busy is withdrawn before the block returns to idle.

// File: rtl/membus_pkg.sv
package membus_pkg;

  // Region codes reported on rsp_region
  typedef enum logic [1:0] {
    REG_GEN  = 2'd0,
    REG_FBUF = 2'd1,
    REG_IO   = 2'd2
  } region_e;

  // Access sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STB,
    ST_RD_CAP,
    ST_WR_STB,
    ST_FIN
  } seq_state_e;

  // Source select for the data holding register
  typedef enum logic [1:0] {
    MDR_FROM_REQ,
    MDR_FROM_BUS,
    MDR_ZERO
  } mdr_src_e;

endpackage

// File: rtl/membus_decode.sv
module membus_decode
  import membus_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned FB_BASE   = 32'h7C40,
  parameter int unsigned FB_WORDS  = 960,
  parameter int unsigned TERM_ADDR = 32'hFFF0
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic          is_term
);

  localparam logic [AW-1:0] FB_LO  = AW'(FB_BASE);
  localparam logic [AW-1:0] FB_HI  = AW'(FB_BASE + FB_WORDS - 1);
  localparam logic [AW-1:0] TERM_A = AW'(TERM_ADDR);

  // The top address bit splits memory from IO space
  always_comb begin
    if (addr[AW-1]) begin
      region = REG_IO;
    end else if ((addr >= FB_LO) && (addr <= FB_HI)) begin
      region = REG_FBUF;
    end else begin
      region = REG_GEN;
    end
  end

  assign is_term = (addr == TERM_A);

endmodule

// File: rtl/membus_regs.sv
module membus_regs
  import membus_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mar_ld,
  input  logic [AW-1:0] mar_d,
  input  logic          mdr_ld,
  input  mdr_src_e      mdr_src,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mdr_q
);

  logic [DW-1:0] mdr_d;

  always_comb begin
    unique case (mdr_src)
      MDR_FROM_REQ: mdr_d = req_data;
      MDR_FROM_BUS: mdr_d = bus_data;
      default:      mdr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (mar_ld) begin
      mar_q <= mar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
    end else if (mdr_ld) begin
      mdr_q <= mdr_d;
    end
  end

endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  input  region_e  region,
  input  logic     is_term,
  output logic     req_ready,
  output logic     mar_ld,
  output logic     mdr_ld,
  output mdr_src_e mdr_src,
  output logic     bus_rd,
  output logic     bus_wr,
  output logic     term_valid,
  output logic     rsp_done
);

  seq_state_e state_q, state_d;
  logic       fire;
  logic       to_mem;

  assign fire   = (state_q == ST_IDLE) && req_valid;
  assign to_mem = (region != REG_IO);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = req_write ? ST_WR_STB : ST_RD_STB;
      ST_RD_STB: state_d = ST_RD_CAP;
      ST_RD_CAP: state_d = ST_FIN;
      ST_WR_STB: state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    mdr_ld  = 1'b0;
    mdr_src = MDR_FROM_REQ;
    if (fire && req_write) begin
      mdr_ld = 1'b1;
    end else if (state_q == ST_RD_CAP) begin
      mdr_ld  = 1'b1;
      mdr_src = to_mem ? MDR_FROM_BUS : MDR_ZERO;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mar_ld     = fire;
  assign bus_rd     = (state_q == ST_RD_STB) && to_mem;
  assign bus_wr     = (state_q == ST_WR_STB) && to_mem;
  assign term_valid = (state_q == ST_WR_STB) && is_term;
  assign rsp_done   = (state_q == ST_FIN);

endmodule

// File: rtl/membus_unit.sv
module membus_unit
  import membus_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned FB_BASE   = 32'h7C40,
  parameter int unsigned FB_WORDS  = 960,
  parameter int unsigned TERM_ADDR = 32'hFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    rsp_region,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_fbuf,
  output logic          term_valid,
  output logic [DW-1:0] term_data
);

  logic          mar_ld, mdr_ld, is_term;
  mdr_src_e      mdr_src;
  region_e       region;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;

  membus_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mar_ld   (mar_ld),
    .mar_d    (req_addr),
    .mdr_ld   (mdr_ld),
    .mdr_src  (mdr_src),
    .req_data (req_wdata),
    .bus_data (bus_rdata),
    .mar_q    (mar_q),
    .mdr_q    (mdr_q)
  );

  // Decode always looks at the latched address, never the live request
  membus_decode #(
    .AW(AW), .FB_BASE(FB_BASE), .FB_WORDS(FB_WORDS), .TERM_ADDR(TERM_ADDR)
  ) dec_i (
    .addr    (mar_q),
    .region  (region),
    .is_term (is_term)
  );

  membus_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .region     (region),
    .is_term    (is_term),
    .req_ready  (req_ready),
    .mar_ld     (mar_ld),
    .mdr_ld     (mdr_ld),
    .mdr_src    (mdr_src),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .term_valid (term_valid),
    .rsp_done   (rsp_done)
  );

  assign bus_addr   = mar_q;
  assign bus_wdata  = mdr_q;
  assign term_data  = mdr_q;
  assign rsp_rdata  = mdr_q;
  assign rsp_region = region;
  assign bus_fbuf   = (bus_rd || bus_wr) && (region == REG_FBUF);

endmodule

// File: rtl/membus_unit_chk.sv
module membus_unit_chk #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned FB_BASE   = 32'h7C40,
  parameter int unsigned FB_WORDS  = 960,
  parameter int unsigned TERM_ADDR = 32'hFFF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_fbuf,
  input logic          term_valid
);

  localparam logic [AW-1:0] FB_LO  = AW'(FB_BASE);
  localparam logic [AW-1:0] FB_HI  = AW'(FB_BASE + FB_WORDS - 1);
  localparam logic [AW-1:0] TERM_A = AW'(TERM_ADDR);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);

  p_rd_to_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> ##2 rsp_done);

  p_wr_to_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> rsp_done);

  p_no_rd_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_fbuf_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fbuf |-> ((bus_rd || bus_wr) && bus_addr >= FB_LO && bus_addr <= FB_HI));

  p_io_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !bus_addr[AW-1]);

  p_term_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (bus_addr == TERM_A && !bus_wr));

  p_term_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> !term_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(bus_addr));

endmodule

bind membus_unit membus_unit_chk #(
  .AW(AW), .DW(DW), .FB_BASE(FB_BASE), .FB_WORDS(FB_WORDS), .TERM_ADDR(TERM_ADDR)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_fbuf   (bus_fbuf),
  .term_valid (term_valid)
);

// File: tb/membus_unit_tb_top.sv
module membus_unit_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_region;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, bus_fbuf, term_valid;
  logic [31:0] bus_wdata, term_data;
  logic [31:0] ram_q = 32'hDEAD_BEEF;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model: one cycle of latency, poison word outside the answer cycle
  always @(posedge clk) begin
    if (bus_rd) ram_q <= {~bus_addr, bus_addr};
    else        ram_q <= 32'hDEAD_BEEF;
  end

  membus_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_region(rsp_region),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(ram_q), .bus_fbuf(bus_fbuf),
    .term_valid(term_valid), .term_data(term_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] region_of(input logic [15:0] a);
    if (a[15]) return 2'd2;
    if (a >= 16'h7C40) return 2'd1;
    return 2'd0;
  endfunction

  // Offer a request; returns at the falling edge after the accepting edge
  task automatic issue(input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    check("R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 bus_rd", bus_rd, 0);
    check("R1 bus_wr", bus_wr, 0);
    check("R1 term_valid", term_valid, 0);
    check("R1 rsp_done", rsp_done, 0);
    check("R1 req_ready", req_ready, 1);
    check("R1 bus_addr", bus_addr, 0);
    check("R1 bus_wdata", bus_wdata, 0);
    check("R1 rsp_rdata", rsp_rdata, 0);
  endtask

  task automatic t_read(input logic [15:0] a);
    logic        ram = ~a[15];
    logic [31:0] exp = ram ? {~a, a} : 32'h0;
    issue(1'b0, a, 32'h0);
    check(ram ? "R3 bus_rd high" : "R6 no bus_rd on IO", bus_rd, ram);
    check("R3 bus_addr", bus_addr, a);
    check("R5 bus_fbuf on read", bus_fbuf, ram && region_of(a) == 2'd1);
    check("R2 ready low while busy", req_ready, 0);
    check("R9 no early done", rsp_done, 0);
    @(negedge clk);
    check("R3 bus_rd one cycle", bus_rd, 0);
    check("R9 no early done", rsp_done, 0);
    @(negedge clk);
    check("R9 read done", rsp_done, 1);
    check(ram ? "R3 read data" : "R6 IO read zero", rsp_rdata, exp);
    check("R5 region", rsp_region, region_of(a));
    @(negedge clk);
    check("R9 done single", rsp_done, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [31:0] d);
    logic ram  = ~a[15];
    logic term = (a == 16'hFFF0);
    issue(1'b1, a, d);
    check(ram ? "R4 bus_wr high" : "R8 no bus_wr on IO", bus_wr, ram);
    check("R4 bus_addr", bus_addr, a);
    check("R4 bus_wdata", bus_wdata, d);
    check("R5 bus_fbuf on write", bus_fbuf, ram && region_of(a) == 2'd1);
    check(term ? "R7 term pulse" : "R8 no term pulse", term_valid, term);
    if (term) check("R7 term_data", term_data, d);
    check("R4 no bus_rd", bus_rd, 0);
    @(negedge clk);
    check("R9 write done", rsp_done, 1);
    check("R5 region", rsp_region, region_of(a));
    check("R4 bus_wr one cycle", bus_wr, 0);
    check("R7 term one cycle", term_valid, 0);
    @(negedge clk);
    check("R9 done single", rsp_done, 0);
  endtask

  // A terminal write offered while a read is in flight must be ignored
  task automatic t_busy_offer();
    issue(1'b0, 16'h0200, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hFFF0; req_wdata = 32'h0000_0041;
    check("R2 ready low while busy", req_ready, 0);
    @(negedge clk);
    check("R2 busy offer no term", term_valid, 0);
    check("R2 busy offer no wr", bus_wr, 0);
    @(negedge clk);
    check("R2 busy offer no term", term_valid, 0);
    check("R9 done under busy offer", rsp_done, 1);
    check("R2 read data intact", rsp_rdata, {~16'h0200, 16'h0200});
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 addr held while idle", bus_addr, 16'h0200);
    check("R2 ready back", req_ready, 1);
    check("R2 busy offer no term", term_valid, 0);
    repeat (2) @(negedge clk);
    check("R10 addr still held", bus_addr, 16'h0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read(16'h0100);
    t_read(16'h7C3F);
    t_read(16'h7C40);
    t_read(16'h7FFF);
    t_read(16'h8000);
    t_read(16'hFFF0);
    t_write(16'h0123, 32'hCAFE_0001);
    t_write(16'h7C40, 32'h1234_5678);
    t_write(16'h7FFF, 32'h8765_4321);
    t_write(16'hFFF0, 32'h0000_0048);
    t_write(16'hFFF0, 32'h0000_0069);
    t_write(16'hFFEF, 32'h5555_AAAA);
    t_write(16'h8000, 32'hFFFF_FFFF);
    t_busy_offer();
    t_read(16'h0123);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule